// File: doc/BRIEF.md
# Reset and Halt Sequencer

This unit decides when a small 4-bit controller core is held in reset, when it runs and when it is frozen. Reset has two sources, combined by OR:

- an active-high reset pin, brought through a synchronizer;
- an internal power-on stretcher, which holds reset for a fixed number of cycles after the power-good input rises.

While reset is active, the unit asks the core to load the start address, which is given as two separate fields: page 31 and word 0x3F. At the same time it forces its own state to fixed values of mixed polarity. That state is a bank of seven core flags, sixteen single-bit output lines and seven 4-bit output ports. It forces nothing else.

The halt pin is active low. While it is low, the core clock enable is dropped and every state element in the unit keeps its value. Halt is a synchronous enable, not a gated clock. A build-time parameter picks one of two behaviours for the pins during halt. In live mode, the outputs, pull-ups and input buffers stay on. In float mode, the output drivers, pull-ups and input buffers are all turned off until halt ends.

Top module: `core_rst_halt_ctrl`

## Requirements
- R1: Reset (`pc_load_o`=1, `core_ce_o`=0) takes effect exactly SYNC_STAGES (2) clock edges after `ext_reset_i` rises. It ends SYNC_STAGES edges after `ext_reset_i` falls, provided power-on reset is complete.
- R2: `pc_page_o` is 31 and `pc_addr_o` is 0x3F.
- R3: While reset is active, `flags_o` is forced to 7'b1110000. Bits 0..3 are the two interrupt requests, the interrupt enable and the carry, all forced to 0. Bits 4..6 are the two external interrupt flags and the timer flag, all forced to 1.
- R4: While reset is active, all 16 bits of `d_o` and all 28 bits of `r_o` are forced to 1.
- R5: When the unit is running, a flag whose `flag_set_i` bit is 1 becomes 1, even if its `flag_clr_i` bit is also 1. A flag with only its clear bit set becomes 0. A flag with neither bit set keeps its value.
- R6: While halted, `flags_o`, `d_o` and `r_o` ignore all set, clear and write inputs. `core_ce_o` is 0 from SYNC_STAGES edges after `halt_n_i` falls.
- R7: With HALT_IO_LIVE=1, `out_en_o`, `pullup_en_o` and `in_en_o` stay 1 during halt.
- R8: With HALT_IO_LIVE=0, `out_en_o`, `pullup_en_o` and `in_en_o` are 0 while halted and return to 1 once halt ends.
- R9: Reset is held until exactly SYNC_STAGES+POR_CYCLES edges after `pwr_good_i` rises. Reset is asserted again when `pwr_good_i` falls.
- R10: Reset takes priority over halt: during halt, an active reset still forces the R3 and R4 values.
- R11: When the unit is running, `d_set_i[i]` drives line i to 1 and wins over `d_clr_i[i]`, which otherwise drives it to 0. `r_we_i[p]` loads `r_wdata_i` into `r_o[4p+3:4p]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| ext_reset_i | input | 1 | External reset pin, active high, asynchronous |
| pwr_good_i | input | 1 | Power-good from the supply detector, asynchronous |
| halt_n_i | input | 1 | Halt pin, active low, asynchronous |
| flag_set_i | input | 7 | Per-flag set requests from the core |
| flag_clr_i | input | 7 | Per-flag clear requests from the core |
| d_set_i | input | 16 | Per-line set requests for the discrete outputs |
| d_clr_i | input | 16 | Per-line clear requests for the discrete outputs |
| r_we_i | input | 7 | Per-port write enables for the 4-bit ports |
| r_wdata_i | input | 4 | Write data for the 4-bit ports |
| pc_load_o | output | 1 | Core must load the start address (reset active) |
| pc_page_o | output | 5 | Start page |
| pc_addr_o | output | 6 | Start word within the page |
| core_ce_o | output | 1 | Core clock enable |
| flags_o | output | 7 | Flag bank |
| d_o | output | 16 | Discrete output latches |
| r_o | output | 28 | 4-bit port output latches, port p in bits 4p+3:4p |
| out_en_o | output | 1 | Output driver enable |
| pullup_en_o | output | 1 | Pull-up enable |
| in_en_o | output | 1 | Input buffer enable |

## Verification
The bench counts edges to confirm that reset rises and falls exactly two cycles after the pin changes and exactly ten cycles after power-good rises. A design with an extra or a missing synchronizer stage, or an off-by-one stretcher, fails at those edges. Every flag is driven through all four set/clear combinations, and every line and port is swept. This exposes clear-over-set priority, swapped reset polarities and wrong field positions. The halt tests push writes into a frozen unit, assert reset while halted, and run live and float builds side by side. A design that leaks updates, lets halt block reset, or drives the I/O enables in the wrong mode fails those tests.

// File: rtl/rhc_pkg.sv
package rhc_pkg;
   localparam int FLAG_N = 7;
   // bit order: irq_a, irq_b, int_en, carry, ext_flag0, ext_flag1, tmr_flag
   localparam logic [FLAG_N-1:0] FLAG_RST = 7'b111_0000;
   localparam int PAGE_W = 5;
   localparam int ADDR_W = 6;
endpackage

// File: rtl/rhc_sync.sv
module rhc_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rhc_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk_i) begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rhc_por.sv
module rhc_por #(
   parameter int POR_CYCLES = 64
) (
   input  logic clk_i,
   input  logic pg_i,
   output logic busy_o
);
   localparam int CNT_W = $clog2(POR_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_END = CNT_W'(POR_CYCLES);

   generate
      if (POR_CYCLES < 1) begin : g_bad_por
         $error("rhc_por needs POR_CYCLES >= 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!pg_i)                cnt_q <= '0;
      else if (cnt_q != CNT_END) cnt_q <= cnt_q + 1'b1;
   end

   assign busy_o = (cnt_q != CNT_END);

   assert_rearm_R9: assert property (@(posedge clk_i) disable iff (pg_i)
      1'b1 |=> busy_o);
endmodule

// File: rtl/rhc_flags.sv
module rhc_flags #(
   parameter int            N       = 7,
   parameter logic [N-1:0]  RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         run_i,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flags_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("rhc_flags needs N >= 1");
      end
   endgenerate

   logic [N-1:0] flags_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)      flags_q <= RST_VAL;
      else if (run_i) flags_q <= set_i | (flags_q & ~clr_i);
   end

   assign flags_o = flags_q;

   assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      run_i |=> ((flags_o & $past(set_i)) == $past(set_i)));
   assert_clear_only_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      run_i |=> ((flags_o & $past(clr_i & ~set_i)) == '0));
   assert_flags_frozen_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      !run_i |=> $stable(flags_o));
endmodule

// File: rtl/rhc_outlatch.sv
module rhc_outlatch #(
   parameter int D_N = 16,
   parameter int R_N = 7,
   parameter int R_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             run_i,
   input  logic [D_N-1:0]   d_set_i,
   input  logic [D_N-1:0]   d_clr_i,
   input  logic [R_N-1:0]   r_we_i,
   input  logic [R_W-1:0]   r_wdata_i,
   output logic [D_N-1:0]   d_o,
   output logic [R_N*R_W-1:0] r_o
);
   generate
      if (D_N < 1 || R_N < 1 || R_W < 1) begin : g_bad_dims
         $error("rhc_outlatch dimensions must be positive");
      end
   endgenerate

   logic [D_N-1:0] d_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)      d_q <= '1;
      else if (run_i) d_q <= d_set_i | (d_q & ~d_clr_i);
   end
   assign d_o = d_q;

   generate
      for (genvar p = 0; p < R_N; p++) begin : g_port
         logic [R_W-1:0] port_q;
         always_ff @(posedge clk_i) begin
            if (rst_i)                  port_q <= '1;
            else if (run_i && r_we_i[p]) port_q <= r_wdata_i;
         end
         assign r_o[p*R_W +: R_W] = port_q;

         assert_port_write_R11: assert property (@(posedge clk_i) disable iff (rst_i)
            (run_i && r_we_i[p]) |=> (r_o[p*R_W +: R_W] == $past(r_wdata_i)));
      end
   endgenerate

   assert_latch_frozen_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      !run_i |=> ($stable(d_o) && $stable(r_o)));
endmodule

// File: rtl/rhc_halt_io.sv
module rhc_halt_io #(
   parameter bit HALT_IO_LIVE = 1'b1
) (
   input  logic halted_i,
   output logic out_en_o,
   output logic pullup_en_o,
   output logic in_en_o
);
   logic io_live;
   assign io_live     = halted_i ? HALT_IO_LIVE : 1'b1;
   assign out_en_o    = io_live;
   assign pullup_en_o = io_live;
   assign in_en_o     = io_live;
endmodule

// File: rtl/core_rst_halt_ctrl.sv
module core_rst_halt_ctrl
   import rhc_pkg::*;
#(
   parameter int  SYNC_STAGES  = 2,
   parameter int  POR_CYCLES   = 64,
   parameter int  D_N          = 16,
   parameter int  R_N          = 7,
   parameter int  R_W          = 4,
   parameter bit  HALT_IO_LIVE = 1'b1,
   parameter logic [PAGE_W-1:0] START_PAGE = 5'd31,
   parameter logic [ADDR_W-1:0] START_ADDR = 6'h3F
) (
   input  logic                 clk_i,
   input  logic                 ext_reset_i,
   input  logic                 pwr_good_i,
   input  logic                 halt_n_i,
   input  logic [FLAG_N-1:0]    flag_set_i,
   input  logic [FLAG_N-1:0]    flag_clr_i,
   input  logic [D_N-1:0]       d_set_i,
   input  logic [D_N-1:0]       d_clr_i,
   input  logic [R_N-1:0]       r_we_i,
   input  logic [R_W-1:0]       r_wdata_i,
   output logic                 pc_load_o,
   output logic [PAGE_W-1:0]    pc_page_o,
   output logic [ADDR_W-1:0]    pc_addr_o,
   output logic                 core_ce_o,
   output logic [FLAG_N-1:0]    flags_o,
   output logic [D_N-1:0]       d_o,
   output logic [R_N*R_W-1:0]   r_o,
   output logic                 out_en_o,
   output logic                 pullup_en_o,
   output logic                 in_en_o
);
   logic [2:0] pins_s;
   logic       ext_rst_s, pg_s, halt_n_s;
   logic       por_busy, rst, halted, run;

   rhc_sync #(.STAGES(SYNC_STAGES), .W(3)) i_sync (
      .clk_i (clk_i),
      .d_i   ({ext_reset_i, pwr_good_i, halt_n_i}),
      .q_o   (pins_s)
   );
   assign {ext_rst_s, pg_s, halt_n_s} = pins_s;

   rhc_por #(.POR_CYCLES(POR_CYCLES)) i_por (
      .clk_i  (clk_i),
      .pg_i   (pg_s),
      .busy_o (por_busy)
   );

   assign rst    = ext_rst_s | por_busy;
   assign halted = ~halt_n_s;
   assign run    = ~halted;

   rhc_flags #(.N(FLAG_N), .RST_VAL(FLAG_RST)) i_flags (
      .clk_i   (clk_i),
      .rst_i   (rst),
      .run_i   (run),
      .set_i   (flag_set_i),
      .clr_i   (flag_clr_i),
      .flags_o (flags_o)
   );

   rhc_outlatch #(.D_N(D_N), .R_N(R_N), .R_W(R_W)) i_latch (
      .clk_i     (clk_i),
      .rst_i     (rst),
      .run_i     (run),
      .d_set_i   (d_set_i),
      .d_clr_i   (d_clr_i),
      .r_we_i    (r_we_i),
      .r_wdata_i (r_wdata_i),
      .d_o       (d_o),
      .r_o       (r_o)
   );

   rhc_halt_io #(.HALT_IO_LIVE(HALT_IO_LIVE)) i_hio (
      .halted_i    (halted),
      .out_en_o    (out_en_o),
      .pullup_en_o (pullup_en_o),
      .in_en_o     (in_en_o)
   );

   assign pc_load_o = rst;
   assign pc_page_o = START_PAGE;
   assign pc_addr_o = START_ADDR;
   assign core_ce_o = ~rst & run;
endmodule

// File: tb/test_core_rst_halt_ctrl.sv
module test_core_rst_halt_ctrl;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        ext_reset, pwr_good, halt_n;
   logic [6:0]  fset, fclr;
   logic [15:0] dset, dclr;
   logic [6:0]  rwe;
   logic [3:0]  rwd;

   logic        pl_a, ce_a, oe_a, pu_a, ie_a;
   logic [4:0]  pg_a;
   logic [5:0]  pa_a;
   logic [6:0]  fl_a;
   logic [15:0] d_a;
   logic [27:0] r_a;
   logic        pl_b, ce_b, oe_b, pu_b, ie_b;
   logic [4:0]  pg_b;
   logic [5:0]  pa_b;
   logic [6:0]  fl_b;
   logic [15:0] d_b;
   logic [27:0] r_b;

   core_rst_halt_ctrl #(.POR_CYCLES(8), .HALT_IO_LIVE(1'b1)) i_core_rst_halt_ctrl (
      .clk_i(clk), .ext_reset_i(ext_reset), .pwr_good_i(pwr_good), .halt_n_i(halt_n),
      .flag_set_i(fset), .flag_clr_i(fclr), .d_set_i(dset), .d_clr_i(dclr),
      .r_we_i(rwe), .r_wdata_i(rwd), .pc_load_o(pl_a), .pc_page_o(pg_a), .pc_addr_o(pa_a),
      .core_ce_o(ce_a), .flags_o(fl_a), .d_o(d_a), .r_o(r_a),
      .out_en_o(oe_a), .pullup_en_o(pu_a), .in_en_o(ie_a));

   core_rst_halt_ctrl #(.POR_CYCLES(8), .HALT_IO_LIVE(1'b0)) i_core_rst_halt_ctrl_float (
      .clk_i(clk), .ext_reset_i(ext_reset), .pwr_good_i(pwr_good), .halt_n_i(halt_n),
      .flag_set_i(fset), .flag_clr_i(fclr), .d_set_i(dset), .d_clr_i(dclr),
      .r_we_i(rwe), .r_wdata_i(rwd), .pc_load_o(pl_b), .pc_page_o(pg_b), .pc_addr_o(pa_b),
      .core_ce_o(ce_b), .flags_o(fl_b), .d_o(d_b), .r_o(r_b),
      .out_en_o(oe_b), .pullup_en_o(pu_b), .in_en_o(ie_b));

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [6:0]  m_fl;
   logic [15:0] m_d;
   logic [27:0] m_r;

   task automatic ceq(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic idle_in();
      fset = '0; fclr = '0; dset = '0; dclr = '0; rwe = '0; rwd = '0;
   endtask

   task automatic check_state(input string req);
      ceq({req, " flags"}, 32'(fl_a), 32'(m_fl));
      ceq({req, " flags float"}, 32'(fl_b), 32'(m_fl));
      ceq({req, " d"}, 32'(d_a), 32'(m_d));
      ceq({req, " r"}, 32'(r_a), 32'(m_r));
   endtask

   task automatic model_reset();
      m_fl = 7'b111_0000; m_d = '1; m_r = '1;
   endtask

   initial begin
      ext_reset = 1'b0; pwr_good = 1'b0; halt_n = 1'b1;
      idle_in();
      @(negedge clk);
      steps(3);
      // R9 / R1 / R2 / R3 / R4: reset state while power is not good
      model_reset();
      ceq("R9 por active", 32'(pl_a), 32'd1);
      ceq("R1 core_ce low in reset", 32'(ce_a), 32'd0);
      ceq("R2 page", 32'(pg_a), 32'd31);
      ceq("R2 addr", 32'(pa_a), 32'h3F);
      check_state("R3 R4 reset values");

      // R9: exact release edge
      pwr_good = 1'b1;
      for (int k = 1; k <= 10; k++) begin
         step();
         if (k == 9)  ceq("R9 still held at edge 9", 32'(pl_a), 32'd1);
         if (k == 10) ceq("R9 released at edge 10", 32'(pl_a), 32'd0);
      end
      ceq("R1 core_ce high when running", 32'(ce_a), 32'd1);

      // R5: every flag through every set/clear combination
      for (int b = 0; b < 7; b++) begin
         for (int sc = 0; sc < 4; sc++) begin
            fset = '0; fclr = '0;
            fset[b] = sc[1]; fclr[b] = sc[0];
            step();
            if (sc[1]) m_fl[b] = 1'b1;
            else if (sc[0]) m_fl[b] = 1'b0;
            fset = '0; fclr = '0;
            ceq("R5 flag set/clear", 32'(fl_a), 32'(m_fl));
         end
      end

      // R11: discrete lines, clear then set-and-clear together
      for (int i = 0; i < 16; i++) begin
         dclr = '0; dset = '0; dclr[i] = 1'b1;
         step(); m_d[i] = 1'b0;
         ceq("R11 line clear", 32'(d_a), 32'(m_d));
         if (i % 2 == 0) begin
            dset[i] = 1'b1;
            step(); m_d[i] = 1'b1;
            ceq("R11 line set wins", 32'(d_a), 32'(m_d));
         end
      end
      dset = '0; dclr = '0;

      // R11: 4-bit ports
      for (int p = 0; p < 7; p++) begin
         rwe = '0; rwe[p] = 1'b1; rwd = 4'((p * 3 + 5) & 15);
         step();
         m_r[p*4 +: 4] = 4'((p * 3 + 5) & 15);
         ceq("R11 port write", 32'(r_a), 32'(m_r));
      end
      rwe = '0;

      // R6 / R7 / R8: halt entry latency and frozen state
      halt_n = 1'b0;
      step();
      ceq("R6 ce still high edge 1", 32'(ce_a), 32'd1);
      step();
      ceq("R6 ce low edge 2", 32'(ce_a), 32'd0);
      ceq("R7 live out_en", 32'({oe_a, pu_a, ie_a}), 32'h7);
      ceq("R8 float enables off", 32'({oe_b, pu_b, ie_b}), 32'h0);
      fset = 7'h55; fclr = 7'h2A; dset = 16'hFFFF; dclr = 16'h00FF; rwe = '1; rwd = 4'h9;
      steps(3);
      idle_in();
      check_state("R6 halted ignores writes");
      ceq("R6 float flags frozen", 32'(fl_b), 32'(m_fl));

      // R10: reset during halt
      ext_reset = 1'b1;
      steps(4);
      model_reset();
      check_state("R10 reset wins over halt");
      ceq("R8 float still off in reset", 32'(oe_b), 32'd0);
      ext_reset = 1'b0;
      steps(3);
      ceq("R1 reset released", 32'(pl_a), 32'd0);
      ceq("R6 still halted", 32'(ce_a), 32'd0);
      halt_n = 1'b1;
      steps(3);
      ceq("R8 float enables back", 32'({oe_b, pu_b, ie_b}), 32'h7);
      ceq("R6 ce back after halt", 32'(ce_b), 32'd1);

      // R1 exact latency of the external pin, R3/R4 on a disturbed state
      fset = 7'h0F; fclr = 7'h70; dclr = '1; rwe = '1; rwd = 4'h0;
      step();
      idle_in();
      m_fl = 7'h0F; m_d = '0; m_r = '0;
      check_state("R5 R11 disturb");
      ext_reset = 1'b1;
      step();
      ceq("R1 no reset at edge 1", 32'(pl_a), 32'd0);
      step();
      ceq("R1 reset at edge 2", 32'(pl_a), 32'd1);
      ceq("R1 ce low", 32'(ce_a), 32'd0);
      step();
      model_reset();
      check_state("R3 R4 after pin reset");
      ext_reset = 1'b0;
      step();
      ceq("R1 held edge 1 after release", 32'(pl_a), 32'd1);
      step();
      ceq("R1 released edge 2", 32'(pl_a), 32'd0);

      // R9: power loss re-arms reset
      pwr_good = 1'b0;
      steps(3);
      ceq("R9 power loss resets", 32'(pl_a), 32'd1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int c = 0; c < 20000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule